// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-driven SPI master that sends exactly one serial-flash command for each start request. Software writes three 32-bit words through a small register port: a control word, a command/address word and a data word. Setting the start bit launches the command. The engine drops chip select and shifts out the command byte, the three address bytes and any data bytes. It then clocks in up to four reply bytes and stores them in the data word. Busy reads as set until chip select has been released.

The engine is built around a four-state machine. `ST_IDLE` waits for an accepted start and takes the transition *launch* into `ST_SCK_LO`. `ST_SCK_LO` holds SCK low for one half period, then takes *rise* into `ST_SCK_HI`, where MISO is sampled. `ST_SCK_HI` holds SCK high for one half period. From there, *fall* returns to `ST_SCK_LO` and presents the next bit, or *finish* enters `ST_TRAIL` after the last bit of the last byte. `ST_TRAIL` keeps chip select low for one full SCK period, then takes *release* back to `ST_IDLE`. One SCK half period lasts `DIV` system clocks.

Top module: `sfc_engine`

## Requirements
- R1: After reset the control word reads 0 with busy clear, the command/address and data words read 0, CS_n is high and SCK is low.
- R2: Word index 0 is control, with the transmit count in bits [3:0], the receive count in bits [7:4], start in bit 8 (reads 0) and busy in bit 16. Word index 1 is command/address, and word index 2 is data. Index 3 reads 0. Counts read back exactly as written.
- R3: A control write with bit 8 set and a nonzero transmit count, made while idle, drives CS_n low on the next clock edge and sets busy. Busy stays set until CS_n returns high.
- R4: The transmit bytes go out in this order: command/address bits [7:0], then [31:24], [23:16] and [15:8], then data bits [7:0], [15:8], [23:16] and [31:24]. The transmit count includes the command byte.
- R5: Receive byte j, counting from 0, is written into data bits [8j+7:8j]. Data bytes above the receive count keep their value.
- R6: MOSI is low during every receive byte.
- R7: Transfers use SPI mode 0, MSB first. SCK idles low, and each high or low phase lasts DIV clocks. The first bit is valid when CS_n falls. SCK pulses exactly 8 times for each transferred byte.
- R8: CS_n rises exactly 2*DIV clocks after the last falling edge of SCK.
- R9: While busy, writes to any word are ignored, including a second start, and they do not produce a second frame.
- R10: A start with a transmit count of 0 produces no frame and busy stays clear. The counts are still stored.
- R11: A transmit count above 8 acts as 8 and a receive count above 4 acts as 4. The control word still reads back the raw counts.
- R12: A one-byte command with a one-byte reply, such as status read 0x05, returns the reply in data bits [7:0]. Bit 0 of that reply is the write-in-progress flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 2 | Word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_word, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a register write that lands in the middle of a running frame. The bench only sees that such a write was dropped if the frame that follows still carries the original counts, address and data. The stimulus therefore writes a new start with inverted counts, plus inverted command and data words, right after a launch. It then checks the full frame, the number of chip-select falls and the readback. Random count pairs up to 15 reach the clamping boundary, and a modelled flash drives a random reply stream so that each receive slot can be checked.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCK_LO,
        ST_SCK_HI,
        ST_TRAIL
    } sfc_state_e;

    localparam logic [1:0] W_CTL = 2'd0;
    localparam logic [1:0] W_CMD = 2'd1;
    localparam logic [1:0] W_DAT = 2'd2;
    localparam int GO_BIT   = 8;
    localparam int BUSY_BIT = 16;
    localparam logic [3:0] TX_MAX = 4'd8;
    localparam logic [3:0] RX_MAX = 4'd4;
endpackage

// File: rtl/sfc_tick.sv
module sfc_tick #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sfc_txbyte.sv
module sfc_txbyte (
    input  logic [2:0]  idx,
    input  logic [31:0] cmd,
    input  logic [31:0] dat,
    output logic [7:0]  byte_o
);
    logic [7:0] lane [8];

    assign lane[0] = cmd[7:0];
    assign lane[1] = cmd[31:24];
    assign lane[2] = cmd[23:16];
    assign lane[3] = cmd[15:8];

    for (genvar k = 0; k < 4; k++) begin : g_dlane
        assign lane[4+k] = dat[8*k +: 8];
    end

    assign byte_o = lane[idx];
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_word,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int TW = (DIV < 2) ? 1 : $clog2(2 * DIV);
    localparam logic [TW-1:0] HALF_LD  = TW'(DIV - 1);
    localparam logic [TW-1:0] TRAIL_LD = TW'(2 * DIV - 1);

    sfc_state_e state_q, state_d;

    logic [7:0]  ctl_q;
    logic [31:0] cmd_q, dat_q;
    logic [3:0]  txn_q, tot_q, byte_q;
    logic [2:0]  bit_q;
    logic [7:0]  txsh_q, rxsh_q;

    logic        busy, wr_ctl, wr_cmd, wr_dat, go;
    logic [3:0]  tx_req, rx_req, rx_off;
    logic        last_bit, last_byte, in_rx;
    logic [1:0]  rx_slot;
    logic [2:0]  lane_idx;
    logic [7:0]  lane_byte;
    logic        tmr_zero, tmr_load;
    logic [TW-1:0] tmr_val;

    assign busy   = (state_q != ST_IDLE);
    assign wr_ctl = reg_wr && (reg_word == W_CTL) && !busy;
    assign wr_cmd = reg_wr && (reg_word == W_CMD) && !busy;
    assign wr_dat = reg_wr && (reg_word == W_DAT) && !busy;
    assign go     = wr_ctl && reg_wdata[GO_BIT] && (reg_wdata[3:0] != 4'd0);
    assign tx_req = (reg_wdata[3:0] > TX_MAX) ? TX_MAX : reg_wdata[3:0];
    assign rx_req = (reg_wdata[7:4] > RX_MAX) ? RX_MAX : reg_wdata[7:4];

    assign last_bit  = (bit_q == 3'd7);
    assign last_byte = (byte_q == tot_q - 4'd1);
    assign in_rx     = (byte_q >= txn_q);
    assign rx_off    = byte_q - txn_q;
    assign rx_slot   = rx_off[1:0];
    assign lane_idx  = busy ? (byte_q[2:0] + 3'd1) : 3'd0;

    sfc_txbyte u_lane (
        .idx    (lane_idx),
        .cmd    (cmd_q),
        .dat    (dat_q),
        .byte_o (lane_byte)
    );

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = (state_d == ST_TRAIL) ? TRAIL_LD : HALF_LD;

    sfc_tick #(.W(TW)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go)       state_d = ST_SCK_LO;
            ST_SCK_LO: if (tmr_zero) state_d = ST_SCK_HI;
            ST_SCK_HI: if (tmr_zero) state_d = (last_bit && last_byte) ? ST_TRAIL : ST_SCK_LO;
            ST_TRAIL:  if (tmr_zero) state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            cmd_q   <= '0;
            dat_q   <= '0;
            txn_q   <= '0;
            tot_q   <= '0;
            byte_q  <= '0;
            bit_q   <= '0;
            txsh_q  <= '0;
            rxsh_q  <= '0;
        end else begin
            state_q <= state_d;
            if (wr_ctl) ctl_q <= reg_wdata[7:0];
            if (wr_cmd) cmd_q <= reg_wdata;
            if (wr_dat) dat_q <= reg_wdata;
            if (go) begin
                txn_q  <= tx_req;
                tot_q  <= tx_req + rx_req;
                byte_q <= '0;
                bit_q  <= '0;
                txsh_q <= lane_byte;
            end
            if (state_q == ST_SCK_LO && tmr_zero)
                rxsh_q <= {rxsh_q[6:0], spi_miso};
            if (state_q == ST_SCK_HI && tmr_zero) begin
                if (last_bit) begin
                    bit_q  <= '0;
                    byte_q <= byte_q + 4'd1;
                    txsh_q <= lane_byte;
                    if (in_rx) dat_q[{rx_slot, 3'b000} +: 8] <= rxsh_q;
                end else begin
                    bit_q  <= bit_q + 3'd1;
                    txsh_q <= {txsh_q[6:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        spi_sck  = (state_q == ST_SCK_HI);
        spi_cs_n = (state_q == ST_IDLE);
        spi_mosi = (state_q == ST_SCK_LO || state_q == ST_SCK_HI) && !in_rx && txsh_q[7];
        unique case (reg_word)
            W_CTL:   reg_rdata = {15'd0, busy, 8'd0, ctl_q};
            W_CMD:   reg_rdata = cmd_q;
            W_DAT:   reg_rdata = dat_q;
            default: reg_rdata = '0;
        endcase
    end

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == W_CTL && reg_wdata[GO_BIT] && reg_wdata[3:0] != 4'd0 && spi_cs_n)
        |=> !spi_cs_n);

    // R10
    zero_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_word == W_CTL && reg_wdata[3:0] == 4'd0 && spi_cs_n)
        |=> spi_cs_n);

    // R9
    busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !spi_cs_n) |=> ($stable(ctl_q) && $stable(cmd_q)));

    // R5
    dat_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && !(reg_wr && reg_word == W_DAT)) |=> $stable(dat_q));

    // R7
    byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> (byte_q <= tot_q && tot_q <= TX_MAX + RX_MAX));
endmodule

// File: tb/sim_sfc_engine.sv
module sim_sfc_engine;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_word = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_miso;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    sfc_engine #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // flash model: capture MOSI on SCK rise, reset on CS fall
    logic        cap [0:127];
    int          nr = 0;
    int          cs_falls = 0;
    logic [95:0] miso_stream = '0;

    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (!spi_sck) begin
            nr = 0;
            cs_falls = cs_falls + 1;
        end else begin
            if (nr < 128) cap[nr] = spi_mosi;
            nr = nr + 1;
        end
    end

    int midx;
    always_comb begin
        midx = spi_sck ? nr - 1 : nr;
        spi_miso = (midx >= 0 && midx < 96) ? miso_stream[95 - midx] : 1'b0;
    end

    // phase-length monitor
    logic [1:0] ph_prev = 2'b10;
    int run = 0, hi_bad = 0, lo_bad = 0, trail_len = 0;
    always @(negedge clk) begin
        if ({spi_cs_n, spi_sck} == ph_prev) run = run + 1;
        else begin
            if (ph_prev == 2'b01 && run != DIV) hi_bad = hi_bad + 1;
            if (ph_prev == 2'b00) begin
                if (spi_cs_n) trail_len = run;
                else if (run != DIV) lo_bad = lo_bad + 1;
            end
            run = 1;
            ph_prev = {spi_cs_n, spi_sck};
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = w; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] v);
        reg_word = w;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [7:0] exp_tx(input int i, input logic [31:0] c, input logic [31:0] d);
        case (i)
            0: return c[7:0];
            1: return c[31:24];
            2: return c[23:16];
            3: return c[15:8];
            default: return d[8*(i-4) +: 8];
        endcase
    endfunction

    task automatic xfer(input logic [3:0] tx, input logic [3:0] rx,
                        input logic [31:0] c, input logic [31:0] d, input bit poke);
        int txe, rxe, tot, f0, hb0, lb0, zbits;
        logic [31:0] v, expd;
        logic [7:0] b;
        txe = (tx > 8) ? 8 : int'(tx);
        rxe = (rx > 4) ? 4 : int'(rx);
        tot = txe + rxe;
        wr(2'd1, c);
        wr(2'd2, d);
        miso_stream = {$urandom, $urandom, $urandom};
        f0 = cs_falls; hb0 = hi_bad; lb0 = lo_bad;
        wr(2'd0, {23'd0, 1'b1, rx, tx});
        rd(2'd0, v);
        if (tx == 4'd0) begin
            chk(v[16] == 1'b0, "R10 busy stays clear", v, 32'd0);
            repeat (20) @(negedge clk);
            chk(cs_falls == f0, "R10 no frame", cs_falls - f0, 0);
            rd(2'd0, v);
            chk(v[7:0] == {rx, tx}, "R10 counts stored", v, {24'd0, rx, tx});
            return;
        end
        chk(v[16] == 1'b1 && spi_cs_n == 1'b0, "R3 busy and CS low", v, 32'h10000);
        if (poke) begin
            wr(2'd0, {23'd0, 1'b1, ~rx, ~tx});
            wr(2'd1, ~c);
            wr(2'd2, ~d);
        end
        forever begin
            @(negedge clk);
            rd(2'd0, v);
            if (!v[16]) break;
        end
        chk(spi_cs_n == 1'b1, "R3 CS high when busy clears", spi_cs_n, 1);
        chk(nr == tot * 8, (tx > 8 || rx > 4) ? "R11 clamped bit count" : "R7 bit count", nr, tot * 8);
        for (int i = 0; i < txe; i++) begin
            for (int k = 0; k < 8; k++) b[7-k] = cap[8*i + k];
            chk(b == exp_tx(i, c, d), "R4 transmit byte", b, exp_tx(i, c, d));
        end
        zbits = 0;
        for (int k = 8 * txe; k < 8 * tot; k++) if (cap[k] !== 1'b0) zbits++;
        chk(zbits == 0, "R6 MOSI low in receive", zbits, 0);
        expd = d;
        for (int j = 0; j < rxe; j++) expd[8*j +: 8] = miso_stream[95 - 8*(txe + j) -: 8];
        rd(2'd2, v);
        chk(v == expd, "R5 receive placement", v, expd);
        chk(hi_bad == hb0 && lo_bad == lb0, "R7 half periods", hi_bad + lo_bad, hb0 + lb0);
        chk(trail_len == 2 * DIV, "R8 CS release", trail_len, 2 * DIV);
        rd(2'd0, v);
        chk(v[7:0] == {rx, tx}, poke ? "R9 control unchanged" : "R2 control readback", v, {24'd0, rx, tx});
        if (poke) begin
            rd(2'd1, v);
            chk(v == c, "R9 command word unchanged", v, c);
            chk(cs_falls == f0 + 1, "R9 single frame", cs_falls - f0, 1);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] v, c, d;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        rd(2'd0, v); chk(v == 32'd0, "R1 control reset", v, 0);
        rd(2'd1, v); chk(v == 32'd0, "R1 command reset", v, 0);
        rd(2'd2, v); chk(v == 32'd0, "R1 data reset", v, 0);
        chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins idle", {spi_cs_n, spi_sck}, 2'b10);
        // R2
        wr(2'd1, 32'hA1B2C3D4); rd(2'd1, v); chk(v == 32'hA1B2C3D4, "R2 command readback", v, 32'hA1B2C3D4);
        wr(2'd2, 32'h11223344); rd(2'd2, v); chk(v == 32'h11223344, "R2 data readback", v, 32'h11223344);
        rd(2'd3, v); chk(v == 32'd0, "R2 unused word", v, 0);
        // R12: status read, reply 0x03 (write in progress)
        c = 32'h00000005; d = 32'hCAFEF00D;
        wr(2'd1, c); wr(2'd2, d);
        miso_stream = {8'h00, 8'h03, 80'd0};
        wr(2'd0, {23'd0, 1'b1, 4'd1, 4'd1});
        forever begin @(negedge clk); rd(2'd0, v); if (!v[16]) break; end
        rd(2'd2, v);
        chk(v == 32'hCAFEF003 && v[0], "R12 status reply with WIP", v, 32'hCAFEF003);
        // directed: page program with 4 data bytes, full read, clamp, zero count, busy poke
        xfer(4'd8, 4'd0, 32'h123456_02, 32'hDEADBEEF, 1'b0);
        xfer(4'd4, 4'd4, 32'h000010_03, 32'h0, 1'b0);
        xfer(4'd15, 4'd15, 32'h89ABCD_EF, 32'h01234567, 1'b0);
        xfer(4'd0, 4'd3, 32'h0, 32'h0, 1'b0);
        xfer(4'd5, 4'd2, 32'h55AA55_0B, 32'hF0E1D2C3, 1'b1);
        xfer(4'd1, 4'd0, 32'h000000_06, 32'h0, 1'b1);
        for (int n = 0; n < 40; n++) begin
            xfer(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), $urandom, $urandom,
                 ($urandom_range(0, 3) == 0));
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule